// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Interrupt Combiner

This block sits between a processor and a serial audio port. It holds words in two small queues of eight entries each. The transmit queue is filled by the processor and emptied by the audio side. The receive queue is filled by the audio side and emptied by the processor. Each queue reports its fill count, its empty and full state, and a threshold flag. The two threshold flags use opposite comparisons: the receive flag marks "more than enough to read" and the transmit flag marks "running low".

Misuse from the processor is absorbed and reported. A write into a full transmit queue is thrown away. A read from an empty receive queue returns zero. Each of these events sets a sticky flag, and the flag stays set until a clear pulse arrives. The two sticky flags and the two threshold flags are the four interrupt sources. Each source has an enable bit, and one interrupt line is high whenever any enabled source is active. A channel bit flips each time the audio side takes a word from the transmit queue, so it tracks whether a left or a right word is in flight.

Top module: `audio_fifo_pair`

## Requirements
- R1: Each queue's level is a 4-bit count that stays between 0 and 8. The empty flag is 1 exactly when the level is 0, and the full flag is 1 exactly when the level is 8. An audio-side push into a full receive queue and an audio-side pop from an empty transmit queue do nothing.
- R2: `rx_thr_flag` is 1 when the receive level is strictly greater than `rx_thresh`, and 0 otherwise.
- R3: `tx_thr_flag` is 1 when the transmit level is strictly less than `tx_thresh`, and 0 otherwise.
- R4: When the transmit queue is full and no pop happens in the same cycle, a processor write is discarded. The level and the stored words stay as they were.
- R5: A processor read while the receive queue is empty presents all-zero data on `cpu_rx_data`, and the level stays 0. On the audio side, `aud_tx_data` also reads zero while the transmit queue is empty.
- R6: After reset both queues are empty, both empty flags are 1 and both full flags are 0. `rx_thr_flag` is 0, and `tx_thr_flag` is 1 when `tx_thresh` is nonzero. `chan_right` is 1, both sticky flags are 0 and `irq` is 0.
- R7: A processor write attempt while the transmit queue is full and not popped sets `tx_ovf_flag`. The flag stays 1 until a cycle with `tx_ovf_clr` high and no new overflow event, which clears it.
- R8: A processor read attempt while the receive queue is empty sets `rx_udf_flag`. The flag stays 1 until a cycle with `rx_udf_clr` high and no new underflow event, which clears it.
- R9: `irq` is the OR of the enabled sources. The enable bits map as follows: `irq_en[0]` enables the transmit overflow, `irq_en[1]` the receive underflow, `irq_en[2]` the transmit threshold and `irq_en[3]` the receive threshold. When `irq_en` is 0, `irq` is 0.
- R10: A push and a pop on a non-empty queue in the same cycle leave the level unchanged. On a full transmit queue, a write together with a pop is accepted.
- R11: `chan_right` flips on each cycle in which the audio side takes a word from a non-empty transmit queue. Otherwise it holds its value.
- R12: Words leave each queue in the order they were accepted, and the head word is visible on the read data output before it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tx_wr | input | 1 | Processor write strobe for the transmit queue |
| cpu_tx_data | input | 16 | Processor write word |
| cpu_rx_rd | input | 1 | Processor read strobe for the receive queue; pops the head word |
| cpu_rx_data | output | 16 | Receive head word, or zero when the queue is empty |
| tx_thresh | input | 4 | Transmit threshold |
| rx_thresh | input | 4 | Receive threshold |
| irq_en | input | 4 | Interrupt source enables (see R9) |
| tx_ovf_clr | input | 1 | Clear pulse for the overflow flag |
| rx_udf_clr | input | 1 | Clear pulse for the underflow flag |
| aud_tx_pop | input | 1 | Audio side takes the transmit head word |
| aud_tx_data | output | 16 | Transmit head word, or zero when the queue is empty |
| aud_rx_push | input | 1 | Audio side delivers a received word |
| aud_rx_data | input | 16 | Received word |
| tx_level | output | 4 | Transmit fill count |
| rx_level | output | 4 | Receive fill count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_thr_flag | output | 1 | Transmit level below threshold |
| rx_thr_flag | output | 1 | Receive level above threshold |
| tx_ovf_flag | output | 1 | Sticky transmit overflow flag |
| rx_udf_flag | output | 1 | Sticky receive underflow flag |
| chan_right | output | 1 | Channel of the word in flight (0 left, 1 right) |
| irq | output | 1 | Combined interrupt |

## Verification
The main collision is a push and a pop landing on the same queue in one clock. It matters most when the transmit queue is full, because there the write must be accepted instead of being counted as an overflow. The stimulus table drives a write together with an audio pop, once at a middle level and once at level 8. It then checks that the level does not move, that the head advances to the next word, and that the draining that follows yields every accepted word in order, with the word written while full and unpopped missing. The receive side repeats the collision with a processor read and an audio push in the same cycle.

// File: rtl/afp_pkg.sv
package afp_pkg;
  // Interrupt source positions inside the enable / source vectors
  localparam int SRC_TX_OVF = 0;
  localparam int SRC_RX_UDF = 1;
  localparam int SRC_TX_THR = 2;
  localparam int SRC_RX_THR = 3;
  localparam int NSRC       = 4;
endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
  parameter  int W     = 16,
  parameter  int DEPTH = 8,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          dropped,
  output logic          starved
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] level_q, level_d;
  logic          pop_ok, push_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level_q == '0);
  assign full    = (level_q == LW'(DEPTH));
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign dropped = push & ~push_ok;
  assign starved = pop & ~pop_ok;
  assign level   = level_q;
  assign head    = empty ? '0 : mem[rptr_q];

  always_comb begin
    wptr_d  = push_ok ? ptr_inc(wptr_q) : wptr_q;
    rptr_d  = pop_ok  ? ptr_inc(rptr_q) : rptr_q;
    level_d = level_q;
    if (push_ok && !pop_ok) level_d = level_q + 1'b1;
    else if (pop_ok && !push_ok) level_d = level_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      level_q <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(level_q) && full);
  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  assert_pushpop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && push && pop) |=> $stable(level_q));
endmodule

// File: rtl/afp_irq.sv
module afp_irq
  import afp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ovf_evt,
  input  logic            udf_evt,
  input  logic            ovf_clr,
  input  logic            udf_clr,
  input  logic            tx_thr,
  input  logic            rx_thr,
  input  logic [NSRC-1:0] en,
  output logic            ovf_raw,
  output logic            udf_raw,
  output logic            irq
);
  logic            ovf_q, ovf_d, udf_q, udf_d;
  logic [NSRC-1:0] src;

  // a new event in the same cycle outranks the clear pulse
  always_comb begin
    ovf_d = ovf_evt | (ovf_q & ~ovf_clr);
    udf_d = udf_evt | (udf_q & ~udf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  always_comb begin
    src             = '0;
    src[SRC_TX_OVF] = ovf_q;
    src[SRC_RX_UDF] = udf_q;
    src[SRC_TX_THR] = tx_thr;
    src[SRC_RX_THR] = rx_thr;
  end

  assign irq     = |(src & en);
  assign ovf_raw = ovf_q;
  assign udf_raw = udf_q;

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_raw);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_raw && !ovf_clr) |=> ovf_raw);
  assert_udf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> udf_raw);
  assert_udf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_raw && !udf_clr) |=> udf_raw);
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
  assert_irq_rxthr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en[SRC_RX_THR] && rx_thr) |-> irq);
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
  import afp_pkg::*;
#(
  parameter  int W     = 16,
  parameter  int DEPTH = 8,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_tx_wr,
  input  logic [W-1:0]    cpu_tx_data,
  input  logic            cpu_rx_rd,
  output logic [W-1:0]    cpu_rx_data,
  input  logic [LW-1:0]   tx_thresh,
  input  logic [LW-1:0]   rx_thresh,
  input  logic [NSRC-1:0] irq_en,
  input  logic            tx_ovf_clr,
  input  logic            rx_udf_clr,
  input  logic            aud_tx_pop,
  output logic [W-1:0]    aud_tx_data,
  input  logic            aud_rx_push,
  input  logic [W-1:0]    aud_rx_data,
  output logic [LW-1:0]   tx_level,
  output logic [LW-1:0]   rx_level,
  output logic            tx_empty,
  output logic            tx_full,
  output logic            rx_empty,
  output logic            rx_full,
  output logic            tx_thr_flag,
  output logic            rx_thr_flag,
  output logic            tx_ovf_flag,
  output logic            rx_udf_flag,
  output logic            chan_right,
  output logic            irq
);
  logic tx_drop, tx_starve, rx_drop, rx_starve;
  logic chan_q, chan_d;

  afp_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk, .rst_n,
    .push(cpu_tx_wr), .push_data(cpu_tx_data), .pop(aud_tx_pop),
    .head(aud_tx_data), .level(tx_level), .empty(tx_empty), .full(tx_full),
    .dropped(tx_drop), .starved(tx_starve)
  );

  afp_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk, .rst_n,
    .push(aud_rx_push), .push_data(aud_rx_data), .pop(cpu_rx_rd),
    .head(cpu_rx_data), .level(rx_level), .empty(rx_empty), .full(rx_full),
    .dropped(rx_drop), .starved(rx_starve)
  );

  // threshold flags compare the live level with opposite senses
  assign rx_thr_flag = (rx_level > rx_thresh);
  assign tx_thr_flag = (tx_level < tx_thresh);

  afp_irq u_irq (
    .clk, .rst_n,
    .ovf_evt(tx_drop), .udf_evt(rx_starve),
    .ovf_clr(tx_ovf_clr), .udf_clr(rx_udf_clr),
    .tx_thr(tx_thr_flag), .rx_thr(rx_thr_flag),
    .en(irq_en),
    .ovf_raw(tx_ovf_flag), .udf_raw(rx_udf_flag), .irq(irq)
  );

  always_comb chan_d = (aud_tx_pop && !tx_empty) ? ~chan_q : chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= 1'b1;
    else        chan_q <= chan_d;
  end

  assign chan_right = chan_q;

  assert_rx_thr_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_thr_flag);
  assert_tx_thr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_thresh == '0) |-> !tx_thr_flag);
  assert_chan_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !aud_tx_pop |=> $stable(chan_right));
  assert_chan_flip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_tx_pop && !tx_empty) |=> (chan_right != $past(chan_right)));
endmodule

// File: tb/audio_fifo_pair_bench.sv
module audio_fifo_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic        wr;
    logic        pop;
    logic [15:0] din;
    logic [3:0]  lvl;
    logic [15:0] head;
    logic        chan;
  } vec_t;

  // transmit path walk, tx_thresh = 3; expected values after the edge
  localparam vec_t VEC [14] = '{
    '{1'b1, 1'b0, 16'h00A1, 4'd1, 16'h00A1, 1'b1},
    '{1'b1, 1'b0, 16'h00A2, 4'd2, 16'h00A1, 1'b1},
    '{1'b1, 1'b0, 16'h00A3, 4'd3, 16'h00A1, 1'b1},
    '{1'b0, 1'b1, 16'h0000, 4'd2, 16'h00A2, 1'b0},
    '{1'b1, 1'b1, 16'h00A4, 4'd2, 16'h00A3, 1'b1},
    '{1'b1, 1'b0, 16'h00A5, 4'd3, 16'h00A3, 1'b1},
    '{1'b1, 1'b0, 16'h00A6, 4'd4, 16'h00A3, 1'b1},
    '{1'b1, 1'b0, 16'h00A7, 4'd5, 16'h00A3, 1'b1},
    '{1'b1, 1'b0, 16'h00A8, 4'd6, 16'h00A3, 1'b1},
    '{1'b1, 1'b0, 16'h00A9, 4'd7, 16'h00A3, 1'b1},
    '{1'b1, 1'b0, 16'h00AA, 4'd8, 16'h00A3, 1'b1},
    '{1'b1, 1'b0, 16'h00AB, 4'd8, 16'h00A3, 1'b1},
    '{1'b1, 1'b1, 16'h00AC, 4'd8, 16'h00A4, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 4'd7, 16'h00A5, 1'b1}
  };

  localparam logic [15:0] DRAIN [7] = '{16'h00A5, 16'h00A6, 16'h00A7,
                                        16'h00A8, 16'h00A9, 16'h00AA, 16'h00AC};

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_tx_wr, cpu_rx_rd, tx_ovf_clr, rx_udf_clr, aud_tx_pop, aud_rx_push;
  logic [W-1:0] cpu_tx_data, aud_rx_data, cpu_rx_data, aud_tx_data;
  logic [3:0] tx_thresh, rx_thresh, irq_en, tx_level, rx_level;
  logic tx_empty, tx_full, rx_empty, rx_full, tx_thr_flag, rx_thr_flag;
  logic tx_ovf_flag, rx_udf_flag, chan_right, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_fifo_pair u_audio_fifo_pair (
    .clk, .rst_n, .cpu_tx_wr, .cpu_tx_data, .cpu_rx_rd, .cpu_rx_data,
    .tx_thresh, .rx_thresh, .irq_en, .tx_ovf_clr, .rx_udf_clr,
    .aud_tx_pop, .aud_tx_data, .aud_rx_push, .aud_rx_data,
    .tx_level, .rx_level, .tx_empty, .tx_full, .rx_empty, .rx_full,
    .tx_thr_flag, .rx_thr_flag, .tx_ovf_flag, .rx_udf_flag, .chan_right, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_tx_wr = 0; cpu_rx_rd = 0; aud_tx_pop = 0; aud_rx_push = 0;
    tx_ovf_clr = 0; rx_udf_clr = 0;
  endtask

  task automatic rx_push(input logic [15:0] d);
    aud_rx_push = 1; aud_rx_data = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    cpu_tx_data = '0; aud_rx_data = '0;
    tx_thresh = 4'd3; rx_thresh = 4'd2; irq_en = 4'b0000;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R6 reset state
    chk("R6 tx_level", tx_level, 0);
    chk("R6 rx_level", rx_level, 0);
    chk("R6 tx_empty", tx_empty, 1);
    chk("R6 rx_empty", rx_empty, 1);
    chk("R6 tx_full", tx_full, 0);
    chk("R6 rx_full", rx_full, 0);
    chk("R6 rx_thr_flag", rx_thr_flag, 0);
    chk("R6 tx_thr_flag", tx_thr_flag, 1);
    chk("R6 chan_right", chan_right, 1);
    chk("R6 sticky flags", {tx_ovf_flag, rx_udf_flag}, 0);
    chk("R6 irq", irq, 0);

    // table walk: R1 R4 R10 R11 R12 on the transmit queue
    for (int i = 0; i < 14; i++) begin
      cpu_tx_wr = VEC[i].wr; cpu_tx_data = VEC[i].din; aud_tx_pop = VEC[i].pop;
      @(negedge clk);
      idle();
      chk("R1 R4 R10 tx_level", tx_level, VEC[i].lvl);
      chk("R12 R10 tx head", aud_tx_data, VEC[i].head);
      chk("R11 chan_right", chan_right, VEC[i].chan);
      chk("R3 tx_thr_flag", tx_thr_flag, (VEC[i].lvl < 4'd3));
      chk("R1 tx_full", tx_full, (VEC[i].lvl == 4'd8));
    end

    // R7 overflow flag set by the dropped write, R9 masking
    chk("R7 tx_ovf_flag set", tx_ovf_flag, 1);
    chk("R9 irq masked", irq, 0);
    irq_en = 4'b0001;
    @(negedge clk);
    chk("R9 irq from overflow", irq, 1);
    chk("R7 tx_ovf_flag sticky", tx_ovf_flag, 1);
    tx_ovf_clr = 1;
    @(negedge clk);
    idle();
    chk("R7 tx_ovf_flag cleared", tx_ovf_flag, 0);
    chk("R9 irq after clear", irq, 0);

    // drain: R12 order, dropped word absent
    for (int i = 0; i < 7; i++) begin
      chk("R12 drain order", aud_tx_data, DRAIN[i]);
      aud_tx_pop = 1;
      @(negedge clk);
      idle();
    end
    chk("R1 tx_empty after drain", tx_empty, 1);
    chk("R5 aud_tx_data zero when empty", aud_tx_data, 0);
    chk("R11 chan after 11 pops", chan_right, 0);
    aud_tx_pop = 1;
    @(negedge clk);
    idle();
    chk("R11 chan hold on empty pop", chan_right, 0);
    chk("R1 tx_level stays 0", tx_level, 0);

    // R5 and R8: read from empty receive queue
    irq_en = 4'b0010;
    cpu_rx_rd = 1;
    #1;
    chk("R5 empty read data zero", cpu_rx_data, 0);
    @(negedge clk);
    idle();
    chk("R5 rx_level stays 0", rx_level, 0);
    chk("R8 rx_udf_flag set", rx_udf_flag, 1);
    chk("R9 irq from underflow", irq, 1);
    @(negedge clk);
    chk("R8 rx_udf_flag sticky", rx_udf_flag, 1);
    rx_udf_clr = 1;
    @(negedge clk);
    idle();
    chk("R8 rx_udf_flag cleared", rx_udf_flag, 0);
    chk("R9 irq after underflow clear", irq, 0);

    // R2 receive threshold, rx_thresh = 2
    irq_en = 4'b1000;
    rx_push(16'h00B0);
    rx_push(16'h00B1);
    chk("R2 rx_thr at level 2", rx_thr_flag, 0);
    chk("R9 irq rx thr inactive", irq, 0);
    rx_push(16'h00B2);
    chk("R2 rx_thr at level 3", rx_thr_flag, 1);
    chk("R9 irq rx thr active", irq, 1);

    // R10 on receive side: read and push together
    chk("R12 rx head before read", cpu_rx_data, 16'h00B0);
    cpu_rx_rd = 1; aud_rx_push = 1; aud_rx_data = 16'h00B3;
    @(negedge clk);
    idle();
    chk("R10 rx_level unchanged", rx_level, 3);
    chk("R12 rx head advanced", cpu_rx_data, 16'h00B1);

    for (int i = 4; i < 9; i++) rx_push(16'h00B0 + 16'(i));
    chk("R1 rx_level full", rx_level, 8);
    chk("R1 rx_full", rx_full, 1);
    rx_push(16'h00BF);
    chk("R1 rx push on full ignored", rx_level, 8);
    chk("R7 no overflow from audio push", tx_ovf_flag, 0);
    for (int i = 1; i < 9; i++) begin
      chk("R12 rx read order", cpu_rx_data, 16'h00B0 + 16'(i));
      cpu_rx_rd = 1;
      @(negedge clk);
      idle();
    end
    chk("R1 rx_empty after reads", rx_empty, 1);
    chk("R8 no underflow from valid reads", rx_udf_flag, 0);

    // R3 transmit threshold boundaries
    irq_en = 4'b0100;
    tx_thresh = 4'd0;
    #1;
    chk("R3 thresh 0 level 0", tx_thr_flag, 0);
    chk("R9 irq tx thr inactive", irq, 0);
    cpu_tx_wr = 1; cpu_tx_data = 16'h00C1;
    @(negedge clk);
    idle();
    tx_thresh = 4'd2;
    #1;
    chk("R3 level 1 thresh 2", tx_thr_flag, 1);
    chk("R9 irq tx thr active", irq, 1);
    tx_thresh = 4'd1;
    #1;
    chk("R3 level 1 thresh 1", tx_thr_flag, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule